// File: doc/BRIEF.md
# Float Subtract with Parallel Load

This unit carries out one combined instruction in a single clock cycle. The instruction does two things at once. It subtracts one single-precision register from another and writes the difference to a destination register. It also writes a 32-bit word from memory into a second, different register. The unit holds four 32-bit working registers and a five-bit flag register. It decodes the instruction word and updates both destinations and the flags at the same rising edge.

Several rules set the behaviour:
- The sign and zero flags describe the loaded word, not the difference.
- The arithmetic only raises the sticky overflow and underflow flags.
- Results are truncated toward zero.
- Operands with a zero exponent count as zero.
- An encoding that names the same register for both destinations is refused. The unit then raises an error pulse and changes nothing.
- Instruction words with any other opcode are ignored.

Address generation is done elsewhere. The memory word arrives already fetched on `mem_rdata_i`, in the cycle where `issue_i` is high.

Top module: `fsub_ld_unit`

## Requirements
- R1: Bits 31:28 of `instr_i` must equal 0010 for the instruction to act. The register fields sit at [27:26] (subtrahend), [25:24] (minuend), [23:22] (arithmetic destination) and [21:20] (load destination). Bits 19:0 are not used by this unit. An issued word with any other opcode changes no register and no flag, and leaves `illegal_o` low.
- R2: The arithmetic destination receives minuend minus subtrahend in single precision, truncated toward zero. An operand whose exponent field is zero is taken as zero. An exactly zero difference is written as 0x00000000. An exponent field of 255 is handled as an ordinary finite exponent.
- R3: The load destination receives `mem_rdata_i`. Both register writes become visible on `regs_o` after the rising edge that samples `issue_i` high.
- R4: On a legal instruction, flag bit 0 (negative) takes bit 31 of the loaded word and flag bit 1 (zero) is cleared. The exception is a loaded word with exponent bits 30:23 all zero: then bit 1 is set and bit 0 is cleared.
- R5: When the two destination fields are equal, no register and no flag changes. `illegal_o` is high for exactly the cycle after that issue.
- R6: A difference whose biased exponent would reach 255 or more is written as a signed infinity (exponent 0xFF, fraction 0). It also sets flag bit 3 (overflow). This bit is sticky and is never cleared by this instruction.
- R7: A nonzero difference whose biased exponent would be 0 or less is written as a zero with the sign of the difference. It also sets flag bit 2 (underflow), which is sticky.
- R8: Both subtraction operands are read from the values the registers held before the edge. This holds even when a source is also the load destination.
- R9: After reset, all registers, all flags and `illegal_o` are zero. Flag bit 4 (test) is never changed by this unit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| issue_i | input | 1 | Instruction word and memory data are valid this cycle |
| instr_i | input | 32 | Instruction word |
| mem_rdata_i | input | 32 | Memory word for the load half |
| regs_o | output | 128 | Working register k on bits 32k+31:32k |
| flags_o | output | 5 | {test, overflow, underflow, zero, negative} |
| illegal_o | output | 1 | One-cycle pulse after a refused encoding |

## Verification
Every register write and flag update shows on `regs_o` and `flags_o` in the cycle straight after the issue. So a wrong alignment shift, a missed sticky bit or a wrong normalisation count shows up as a wrong word one cycle later. A write to the wrong register shows up the same way. A wrong register read cannot hide behind a later write either: each issue overwrites only two registers, and the other two are compared every cycle. Sticky flags that are dropped, or set wrongly, stay visible for the rest of the run. This lets a single stray overflow or underflow be caught long after it happened.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned EXP_W   = 8;
  localparam int unsigned FRAC_W  = 23;
  localparam int unsigned MANT_W  = FRAC_W + 1;
  localparam int unsigned FIELD_W = 2;
  localparam int unsigned NREGS   = 1 << FIELD_W;
  localparam logic [3:0]  OPC_SUB_LD = 4'b0010;

  localparam int unsigned FLG_NEG = 0;
  localparam int unsigned FLG_ZER = 1;
  localparam int unsigned FLG_UNF = 2;
  localparam int unsigned FLG_OVF = 3;
  localparam int unsigned FLG_TST = 4;
  localparam int unsigned FLG_W   = 5;

  typedef struct packed {
    logic               hit;
    logic               bad;
    logic [FIELD_W-1:0] src_sub;
    logic [FIELD_W-1:0] src_min;
    logic [FIELD_W-1:0] dst_ar;
    logic [FIELD_W-1:0] dst_ld;
  } dec_t;
endpackage

// File: rtl/fsp_decode.sv
module fsp_decode
  import fsp_pkg::*;
(
  input  logic              issue_i,
  input  logic [WORD_W-1:0] instr_i,
  output dec_t              dec_o
);
  always_comb begin
    dec_o         = '0;
    dec_o.src_sub = instr_i[27:26];
    dec_o.src_min = instr_i[25:24];
    dec_o.dst_ar  = instr_i[23:22];
    dec_o.dst_ld  = instr_i[21:20];
    dec_o.hit     = issue_i && (instr_i[31:28] == OPC_SUB_LD);
    dec_o.bad     = dec_o.hit && (instr_i[23:22] == instr_i[21:20]);
  end
endmodule

// File: rtl/fsp_fsub.sv
module fsp_fsub
  import fsp_pkg::*;
(
  input  logic [WORD_W-1:0] minu_i,
  input  logic [WORD_W-1:0] subt_i,
  output logic [WORD_W-1:0] res_o,
  output logic              ovf_o,
  output logic              unf_o
);
  localparam int unsigned ALN_W = MANT_W + 2;
  localparam int unsigned EXT_W = MANT_W + 3;
  localparam int unsigned LZ_W  = $clog2(EXT_W);

  logic              s_a, s_b, swap, eff_sub, sgn, sticky, is_zero;
  logic [EXP_W-1:0]  e_a, e_b, e_big, e_sml, shamt;
  logic [MANT_W-1:0] m_a, m_b, m_big, m_sml;
  logic [ALN_W-1:0]  sml_ext, aligned, lost_mask;
  logic [EXT_W-1:0]  big_al, sml_al, norm;
  logic [EXT_W:0]    sum;
  logic [LZ_W-1:0]   lz;
  logic              found;
  logic signed [9:0] exp_r;
  logic [FRAC_W-1:0] frac;

  always_comb begin
    s_a = minu_i[31];
    s_b = ~subt_i[31];
    e_a = minu_i[30:23];
    e_b = subt_i[30:23];
    m_a = (e_a != '0) ? {1'b1, minu_i[22:0]} : '0;
    m_b = (e_b != '0) ? {1'b1, subt_i[22:0]} : '0;

    swap    = {e_b, m_b} > {e_a, m_a};
    e_big   = swap ? e_b : e_a;
    m_big   = swap ? m_b : m_a;
    e_sml   = swap ? e_a : e_b;
    m_sml   = swap ? m_a : m_b;
    sgn     = swap ? s_b : s_a;
    eff_sub = (s_a != s_b);

    shamt     = e_big - e_sml;
    sml_ext   = {m_sml, 2'b00};
    lost_mask = '0;
    if (shamt >= EXP_W'(ALN_W)) begin
      aligned = '0;
      sticky  = |sml_ext;
    end else begin
      aligned   = sml_ext >> shamt;
      lost_mask = (ALN_W'(1) << shamt) - ALN_W'(1);
      sticky    = |(sml_ext & lost_mask);
    end
    sml_al = {aligned, sticky};
    big_al = {m_big, 3'b000};

    if (eff_sub) sum = {1'b0, big_al} - {1'b0, sml_al};
    else         sum = {1'b0, big_al} + {1'b0, sml_al};

    lz    = '0;
    found = 1'b0;
    for (int i = EXT_W - 1; i >= 0; i--) begin
      if (!found && sum[i]) begin
        lz    = LZ_W'(EXT_W - 1 - i);
        found = 1'b1;
      end
    end
    norm = sum[EXT_W-1:0] << lz;

    if (sum[EXT_W]) begin
      exp_r = 10'(e_big) + 10'sd1;
      frac  = sum[EXT_W-1:4];
    end else begin
      exp_r = 10'(e_big) - 10'(lz);
      frac  = norm[EXT_W-2:3];
    end

    is_zero = (sum == '0);
    ovf_o   = 1'b0;
    unf_o   = 1'b0;
    if (is_zero) begin
      res_o = '0;
    end else if (exp_r >= 10'sd255) begin
      ovf_o = 1'b1;
      res_o = {sgn, 8'hFF, 23'd0};
    end else if (exp_r <= 10'sd0) begin
      unf_o = 1'b1;
      res_o = {sgn, 31'd0};
    end else begin
      res_o = {sgn, exp_r[7:0], frac};
    end
  end
endmodule

// File: rtl/fsp_regfile.sv
module fsp_regfile #(
  parameter int unsigned NUM = 4,
  parameter int unsigned W   = 32,
  localparam int unsigned IDX_W = $clog2(NUM)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ar_we_i,
  input  logic [IDX_W-1:0] ar_idx_i,
  input  logic [W-1:0]     ar_data_i,
  input  logic             ld_we_i,
  input  logic [IDX_W-1:0] ld_idx_i,
  input  logic [W-1:0]     ld_data_i,
  input  logic [IDX_W-1:0] rd_a_idx_i,
  input  logic [IDX_W-1:0] rd_b_idx_i,
  output logic [W-1:0]     rd_a_o,
  output logic [W-1:0]     rd_b_o,
  output logic [NUM*W-1:0] regs_o
);
  logic [W-1:0] q [NUM];

  for (genvar k = 0; k < NUM; k++) begin : g_reg
    logic         en;
    logic [W-1:0] d;

    always_comb begin
      en = (ar_we_i && ar_idx_i == IDX_W'(k)) || (ld_we_i && ld_idx_i == IDX_W'(k));
      d  = (ld_we_i && ld_idx_i == IDX_W'(k)) ? ld_data_i : ar_data_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  q[k] <= '0;
      else if (en)  q[k] <= d;
    end

    assign regs_o[k*W +: W] = q[k];

    assert_load_lands_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ld_we_i && ld_idx_i == IDX_W'(k)) |=> (q[k] == $past(ld_data_i)));
  end

  assign rd_a_o = q[rd_a_idx_i];
  assign rd_b_o = q[rd_b_idx_i];

  assert_no_dup_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ar_we_i && ld_we_i && ar_idx_i == ld_idx_i));
endmodule

// File: rtl/fsp_flags.sv
module fsp_flags
  import fsp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic [WORD_W-1:0] ld_word_i,
  input  logic              ovf_i,
  input  logic              unf_i,
  output logic [FLG_W-1:0]  flags_o
);
  logic [FLG_W-1:0] flg_q, flg_d;
  logic             exp_zero;

  always_comb begin
    exp_zero = (ld_word_i[30:23] == '0);
    flg_d    = flg_q;
    if (upd_i) begin
      flg_d[FLG_ZER] = exp_zero;
      flg_d[FLG_NEG] = ld_word_i[31] && !exp_zero;
      flg_d[FLG_UNF] = flg_q[FLG_UNF] | unf_i;
      flg_d[FLG_OVF] = flg_q[FLG_OVF] | ovf_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flg_q <= '0;
    else if (upd_i) flg_q <= flg_d;
  end

  assign flags_o = flg_q;

  assert_zero_neg_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(flg_q[FLG_ZER] && flg_q[FLG_NEG]));
  assert_unf_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flg_q[FLG_UNF] |=> flg_q[FLG_UNF]);
  assert_ovf_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flg_q[FLG_OVF] |=> flg_q[FLG_OVF]);
  assert_neg_follows_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> (flg_q[FLG_NEG] == ($past(ld_word_i[31]) && $past(ld_word_i[30:23]) != 8'd0)));
endmodule

// File: rtl/fsub_ld_unit.sv
module fsub_ld_unit
  import fsp_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    issue_i,
  input  logic [WORD_W-1:0]       instr_i,
  input  logic [WORD_W-1:0]       mem_rdata_i,
  output logic [NREGS*WORD_W-1:0] regs_o,
  output logic [FLG_W-1:0]        flags_o,
  output logic                    illegal_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_n;
  dec_t              dec;
  logic              exec;
  logic [WORD_W-1:0] op_min, op_sub, diff;
  logic              ovf, unf;
  logic              err_q, err_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  fsp_decode u_dec (
    .issue_i (issue_i),
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  assign exec = dec.hit && !dec.bad;

  fsp_regfile #(.NUM(NREGS), .W(WORD_W)) u_rf (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .ar_we_i    (exec),
    .ar_idx_i   (dec.dst_ar),
    .ar_data_i  (diff),
    .ld_we_i    (exec),
    .ld_idx_i   (dec.dst_ld),
    .ld_data_i  (mem_rdata_i),
    .rd_a_idx_i (dec.src_min),
    .rd_b_idx_i (dec.src_sub),
    .rd_a_o     (op_min),
    .rd_b_o     (op_sub),
    .regs_o     (regs_o)
  );

  fsp_fsub u_sub (
    .minu_i (op_min),
    .subt_i (op_sub),
    .res_o  (diff),
    .ovf_o  (ovf),
    .unf_o  (unf)
  );

  fsp_flags u_flg (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .upd_i     (exec),
    .ld_word_i (mem_rdata_i),
    .ovf_i     (ovf),
    .unf_i     (unf),
    .flags_o   (flags_o)
  );

  assign err_d = dec.bad;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end
  assign illegal_o = err_q;

  assert_illegal_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    illegal_o |-> ($stable(regs_o) && $stable(flags_o)));
  assert_ovf_gives_inf_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    ovf |-> (diff[30:0] == 31'h7F80_0000));
  assert_unf_gives_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    unf |-> (diff[30:0] == 31'd0));
  assert_foreign_opcode_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_n)
    (issue_i && instr_i[31:28] != OPC_SUB_LD) |=> ($stable(regs_o) && $stable(flags_o) && !illegal_o));
endmodule

// File: tb/fsub_ld_unit_tb.sv
`timescale 1ns/1ps
module fsub_ld_unit_tb;
  logic         clk_i = 1'b0;
  logic         rst_ni;
  logic         issue_i;
  logic [31:0]  instr_i;
  logic [31:0]  mem_rdata_i;
  logic [127:0] regs_o;
  logic [4:0]   flags_o;
  logic         illegal_o;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  done = 1'b0;

  logic [31:0] mregs [4];
  logic [4:0]  mflags;
  logic        merr;

  always #2.5 clk_i = ~clk_i;

  fsub_ld_unit u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .issue_i     (issue_i),
    .instr_i     (instr_i),
    .mem_rdata_i (mem_rdata_i),
    .regs_o      (regs_o),
    .flags_o     (flags_o),
    .illegal_o   (illegal_o)
  );

  function automatic logic [31:0] mk(input logic [3:0] op, input logic [1:0] sb,
                                     input logic [1:0] mn, input logic [1:0] da,
                                     input logic [1:0] dl);
    return {op, sb, mn, da, dl, 4'hA, 16'h5A5A};
  endfunction

  // exact integer reference: value = mant * 2^exp, then truncate toward zero
  function automatic logic [31:0] ref_sub(input logic [31:0] a, input logic [31:0] b,
                                          output logic ov, output logic un);
    logic [287:0] ma, mb, mag;
    logic         va, vb, neg;
    int           p, e;
    ov = 1'b0; un = 1'b0;
    ma = (a[30:23] == 0) ? '0 : ({264'd0, 1'b1, a[22:0]} << a[30:23]);
    mb = (b[30:23] == 0) ? '0 : ({264'd0, 1'b1, b[22:0]} << b[30:23]);
    va = a[31]; vb = ~b[31];
    if (va == vb) begin mag = ma + mb; neg = va; end
    else if (ma >= mb) begin mag = ma - mb; neg = va; end
    else begin mag = mb - ma; neg = vb; end
    if (mag == '0) return 32'd0;
    p = 0;
    for (int i = 287; i >= 0; i--) if (mag[i]) begin p = i; break; end
    e = p - 23;
    if (e >= 255) begin ov = 1'b1; return {neg, 8'hFF, 23'd0}; end
    if (e <= 0)   begin un = 1'b1; return {neg, 31'd0}; end
    return {neg, e[7:0], 23'(mag >> (p - 23))};
  endfunction

  function automatic logic [127:0] flat_model();
    return {mregs[3], mregs[2], mregs[1], mregs[0]};
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_step(input logic [31:0] ins, input logic [31:0] mem);
    logic [31:0] old [4];
    logic ov, un;
    logic [31:0] r;
    old  = mregs;
    merr = 1'b0;
    if (ins[31:28] == 4'b0010) begin
      if (ins[23:22] == ins[21:20]) merr = 1'b1;
      else begin
        r = ref_sub(old[ins[25:24]], old[ins[27:26]], ov, un);
        mregs[ins[23:22]] = r;
        mregs[ins[21:20]] = mem;
        mflags[1] = (mem[30:23] == 0);
        mflags[0] = mem[31] && (mem[30:23] != 0);
        mflags[2] = mflags[2] | un;
        mflags[3] = mflags[3] | ov;
      end
    end
  endtask

  task automatic op(input logic [31:0] ins, input logic [31:0] mem, input string tag);
    instr_i     = ins;
    mem_rdata_i = mem;
    issue_i     = 1'b1;
    model_step(ins, mem);
    @(negedge clk_i);
    issue_i = 1'b0;
    chk({tag, " regs"},  regs_o, flat_model());
    chk({tag, " flags"}, {123'd0, flags_o}, {123'd0, mflags});
    chk({tag, " illegal"}, {127'd0, illegal_o}, {127'd0, merr});
  endtask

  function automatic logic [31:0] rnd_f();
    logic [7:0] e;
    int sel;
    sel = $urandom_range(0, 9);
    case (sel)
      0:       e = 8'd0;
      1:       e = 8'($urandom_range(1, 4));
      2:       e = 8'($urandom_range(250, 255));
      default: e = 8'($urandom_range(120, 134));
    endcase
    return {1'($urandom), e, 23'($urandom)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    int seed_init;
    logic [3:0] opc;
    seed_init = $urandom(32'h00C0FFEE);
    rst_ni = 1'b0; issue_i = 1'b0; instr_i = '0; mem_rdata_i = '0;
    for (int k = 0; k < 4; k++) mregs[k] = '0;
    mflags = '0; merr = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    // R9 reset state
    chk("R9 reset regs", regs_o, '0);
    chk("R9 reset flags", {123'd0, flags_o}, '0);
    chk("R9 reset illegal", {127'd0, illegal_o}, '0);

    // R2 R3: r0=3.0, r1=1.0, then r2 = r0 - r1 = 2.0
    op(mk(4'b0010, 2'd3, 2'd3, 2'd2, 2'd0), 32'h4040_0000, "R3 load r0");
    op(mk(4'b0010, 2'd3, 2'd3, 2'd2, 2'd1), 32'h3F80_0000, "R3 load r1");
    op(mk(4'b0010, 2'd1, 2'd0, 2'd2, 2'd3), 32'h4120_0000, "R2 3-1");
    chk("R2 directed diff", {96'd0, regs_o[95:64]}, {96'd0, 32'h4000_0000});
    // R2 exact cancellation gives +0
    op(mk(4'b0010, 2'd0, 2'd0, 2'd2, 2'd3), 32'h3F80_0000, "R2 cancel");
    chk("R2 cancel zero", {96'd0, regs_o[95:64]}, '0);
    // R8: load target r0 is also the minuend; old r0 (3.0) is used
    op(mk(4'b0010, 2'd1, 2'd0, 2'd2, 2'd0), 32'hC2C8_0000, "R8 read-before-write");
    chk("R8 old operand", {96'd0, regs_o[95:64]}, {96'd0, 32'h4000_0000});
    // R4: negative word with zero exponent -> ZF=1, NF=0
    op(mk(4'b0010, 2'd3, 2'd3, 2'd1, 2'd2), 32'h8000_0005, "R4 zero-exp load");
    chk("R4 flags z", {123'd0, flags_o[1:0]}, {123'd0, 2'b10});
    op(mk(4'b0010, 2'd3, 2'd3, 2'd1, 2'd2), 32'hBF80_0000, "R4 negative load");
    chk("R4 flags n", {123'd0, flags_o[1:0]}, {123'd0, 2'b01});
    // R5 illegal: both destinations r1
    op(mk(4'b0010, 2'd0, 2'd2, 2'd1, 2'd1), 32'h1234_5678, "R5 illegal");
    // R1 foreign opcode
    op(mk(4'b0011, 2'd0, 2'd2, 2'd1, 2'd3), 32'h1234_5678, "R1 foreign opcode");
    // R6 overflow: max - (-max)
    op(mk(4'b0010, 2'd3, 2'd3, 2'd2, 2'd0), 32'h7F7F_FFFF, "R6 setup r0");
    op(mk(4'b0010, 2'd3, 2'd3, 2'd2, 2'd1), 32'hFF7F_FFFF, "R6 setup r1");
    op(mk(4'b0010, 2'd1, 2'd0, 2'd2, 2'd3), 32'h4000_0000, "R6 overflow");
    chk("R6 inf result", {96'd0, regs_o[95:64]}, {96'd0, 32'h7F80_0000});
    chk("R6 ovf flag", {127'd0, flags_o[3]}, {127'd0, 1'b1});
    // R7 underflow: tiny - slightly smaller tiny
    op(mk(4'b0010, 2'd3, 2'd3, 2'd2, 2'd0), 32'h0080_0001, "R7 setup r0");
    op(mk(4'b0010, 2'd3, 2'd3, 2'd2, 2'd1), 32'h0080_0000, "R7 setup r1");
    op(mk(4'b0010, 2'd1, 2'd0, 2'd2, 2'd3), 32'h4000_0000, "R7 underflow");
    chk("R7 zero result", {96'd0, regs_o[95:64]}, '0);
    chk("R7 unf flag", {127'd0, flags_o[2]}, {127'd0, 1'b1});
    // R6 sticky after a normal instruction
    op(mk(4'b0010, 2'd3, 2'd3, 2'd2, 2'd1), 32'h3F80_0000, "R6 R7 sticky");
    chk("R6 sticky ovf", {127'd0, flags_o[3]}, {127'd0, 1'b1});
    // reload all registers with random values, then random mix
    for (int k = 0; k < 4; k++)
      op(mk(4'b0010, 2'd0, 2'd0, 2'(k + 1), 2'(k)), rnd_f(), "R3 reload");
    for (int n = 0; n < 400; n++) begin
      opc = ($urandom_range(0, 9) == 0) ? 4'($urandom) : 4'b0010;
      op(mk(opc, 2'($urandom), 2'($urandom), 2'($urandom), 2'($urandom)), rnd_f(),
         "R1 R2 R3 R4 R5 R8 R9 random");
    end
    chk("R9 test flag unchanged", {127'd0, flags_o[4]}, '0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule